// File: doc/BRIEF.md
# Three-Wire Frequency Synthesizer Control Port

This block receives configuration words for a frequency synthesizer over three slow serial lines: a data line, a shift clock and a load-enable strobe. All three lines are first brought into the system clock domain, and their edges are detected there. While load-enable is low, each rising edge of the shift clock moves one data bit into a 23-bit shift register. A rising edge of load-enable copies the shifted word into one of two holding registers. The bit shifted in last chooses which one.

The divider register holds a 13-bit main count, a 5-bit swallow count and a 2-bit charge-pump output select. The main and swallow counts are also presented together as one 18-bit total ratio, equal to 32 × main + swallow. The reference register holds a 13-bit reference count and a 2-bit test field. Each register raises a one-cycle load strobe whenever it takes a new value, so the downstream counters can reload.

A reset clears both registers. On the first clock after reset is released, nonzero defaults are loaded that let the synthesizer lock without a controller.

Top module: `synth_ctrl_port`

## Requirements
- R1: Word order and sampling. A data bit is captured on each rising edge of the shift clock that occurs while load-enable is low. The first bit shifted is D1, then D2 up to D22, and the address bit is shifted last (23 bits in total).
- R2: While load-enable is high, shift-clock edges and data changes leave the shift register unchanged. If load-enable is then lowered and raised again without any shift-clock edge, the same word is latched again.
- R3: On a word with address 1:
  - D1..D13 give the main count, most significant bit first.
  - D14..D18 give the swallow count, most significant bit first.
  - `div_ratio` equals 32 × main + swallow, which is D1..D18 read as one binary number with D1 as the most significant bit.
  - `cp_sel` equals {D22, D21}.
- R4: On a word with address 0:
  - D10..D22 give the reference count, most significant bit first.
  - `test_sel` equals {D9, D8}.
- R5: A word updates only the register its address selects. The other register keeps its value.
- R6: Each update of a register raises that register's load strobe (`div_load` or `ref_load`) for exactly one system clock cycle.
- R7: When more than 23 bits are shifted before the latch, only the last 23 count.
- R8: While reset is asserted, every field output and both strobes are zero.
- R9: On the first clock after reset is released, the defaults are loaded:
  - main count 324, swallow count 4, total ratio 10372 and `cp_sel` = 2'b10;
  - reference count 1280 and `test_sel` = 2'b01;
  - each strobe pulses exactly once.
- R10: The padding bits have no effect on any output: D19 and D20 in an address-1 word, and D1..D7 in an address-0 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data (asynchronous) |
| ser_le | input | 1 | Load enable; a rising edge latches the word (asynchronous) |
| main_cnt | output | 13 | Main count of the feedback divider |
| swallow_cnt | output | 5 | Swallow count of the feedback divider |
| div_ratio | output | 18 | Total feedback ratio, 32 × main + swallow |
| cp_sel | output | 2 | Charge-pump output select {D22, D21} |
| ref_cnt | output | 13 | Reference count |
| test_sel | output | 2 | Test field {D9, D8} |
| div_load | output | 1 | One-cycle strobe when the divider register is updated |
| ref_load | output | 1 | One-cycle strobe when the reference register is updated |

## Verification
The assertions assume that each serial line holds its level for at least a few system clock cycles, so that every pin change is seen as exactly one edge after synchronization. They also assume that load-enable and the shift clock never rise in the same synchronized cycle.

The bench keeps to these conditions. It holds every pin level for two or more cycles, and it changes the data line only while the shift clock is low. It also keeps load-enable low across reset.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
   localparam int WORD_W  = 23;
   localparam int MAIN_W  = 13;
   localparam int SWAL_W  = 5;
   localparam int REF_W   = 13;
   localparam int CP_W    = 2;
   localparam int TEST_W  = 2;
   localparam int RATIO_W = MAIN_W + SWAL_W;

   // Bit k of the stream (D1 first) sits at index WORD_W-k once fully shifted.
   localparam int MAIN_HI = WORD_W - 1;
   localparam int SWAL_HI = MAIN_HI - MAIN_W;
   localparam int PAD_HI  = SWAL_HI - SWAL_W;
   localparam int CP21_IX = WORD_W - 21;
   localparam int CP22_IX = WORD_W - 22;
   localparam int TST8_IX = WORD_W - 8;
   localparam int TST9_IX = WORD_W - 9;
   localparam int ADDR_IX = 0;

   typedef struct packed {
      logic [MAIN_W-1:0] main_cnt;
      logic [SWAL_W-1:0] swal_cnt;
      logic [CP_W-1:0]   cp_sel;
   } div_cfg_t;

   typedef struct packed {
      logic [REF_W-1:0]  ref_cnt;
      logic [TEST_W-1:0] test_sel;
   } ref_cfg_t;
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("sync_bits: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  stage_q[s] <= '0;
               else if (s == 0)
                  stage_q[s] <= din;
               else
                  stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
         assign dout = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
   import synth_ctrl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_clk,
   input  logic              s_data,
   input  logic              s_le,
   output logic [WORD_W-1:0] shreg,
   output logic              le_rise
);
   logic clk_prev, le_prev, shift_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_prev <= 1'b0;
         le_prev  <= 1'b0;
      end else begin
         clk_prev <= s_clk;
         le_prev  <= s_le;
      end
   end

   assign shift_fire = s_clk && !clk_prev && !s_le;
   assign le_rise    = s_le && !le_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shreg <= '0;
      else if (shift_fire)
         shreg <= {shreg[WORD_W-2:0], s_data};
   end

   // R2
   le_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_le |=> $stable(shreg));

   // R1
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_fire |=> shreg[0] == $past(s_data));
endmodule

// File: rtl/word_latch.sv
module word_latch
   import synth_ctrl_pkg::*;
#(
   parameter int unsigned DEF_MAIN = 324,
   parameter int unsigned DEF_SWAL = 4,
   parameter int unsigned DEF_CP   = 2,
   parameter int unsigned DEF_REF  = 1280,
   parameter int unsigned DEF_TEST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              le_rise,
   input  logic [WORD_W-1:0] word,
   output div_cfg_t          div_q,
   output ref_cfg_t          ref_q,
   output logic              div_load,
   output logic              ref_load
);
   localparam div_cfg_t DIV_DEF = '{main_cnt: MAIN_W'(DEF_MAIN),
                                    swal_cnt: SWAL_W'(DEF_SWAL),
                                    cp_sel:   CP_W'(DEF_CP)};
   localparam ref_cfg_t REF_DEF = '{ref_cnt:  REF_W'(DEF_REF),
                                    test_sel: TEST_W'(DEF_TEST)};

   logic     init_pend;
   div_cfg_t div_new;
   ref_cfg_t ref_new;
   logic     pad_unused;

   assign div_new.main_cnt = word[MAIN_HI -: MAIN_W];
   assign div_new.swal_cnt = word[SWAL_HI -: SWAL_W];
   assign div_new.cp_sel   = {word[CP22_IX], word[CP21_IX]};
   assign ref_new.ref_cnt  = word[REF_W:1];
   assign ref_new.test_sel = {word[TST9_IX], word[TST8_IX]};
   assign pad_unused       = ^word[PAD_HI -: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_pend <= 1'b1;
         div_q     <= '0;
         ref_q     <= '0;
         div_load  <= 1'b0;
         ref_load  <= 1'b0;
      end else begin
         init_pend <= 1'b0;
         div_load  <= 1'b0;
         ref_load  <= 1'b0;
         if (init_pend) begin
            div_q    <= DIV_DEF;
            ref_q    <= REF_DEF;
            div_load <= 1'b1;
            ref_load <= 1'b1;
         end else if (le_rise) begin
            if (word[ADDR_IX]) begin
               div_q    <= div_new;
               div_load <= 1'b1;
            end else begin
               ref_q    <= ref_new;
               ref_load <= 1'b1;
            end
         end
      end
   end

   // R5
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_load |-> $stable(div_q));

   // R5
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_load |-> $stable(ref_q));

   // R9
   dual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_load && ref_load) |-> (div_q == DIV_DEF && ref_q == REF_DEF));

   // R6
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_load && !ref_load) |=> !div_load);
endmodule

// File: rtl/synth_ctrl_port.sv
module synth_ctrl_port
   import synth_ctrl_pkg::*;
#(
   parameter int SYNC_STAGES       = 2,
   parameter int unsigned DEF_MAIN = 324,
   parameter int unsigned DEF_SWAL = 4,
   parameter int unsigned DEF_CP   = 2,
   parameter int unsigned DEF_REF  = 1280,
   parameter int unsigned DEF_TEST = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_data,
   input  logic               ser_le,
   output logic [MAIN_W-1:0]  main_cnt,
   output logic [SWAL_W-1:0]  swallow_cnt,
   output logic [RATIO_W-1:0] div_ratio,
   output logic [CP_W-1:0]    cp_sel,
   output logic [REF_W-1:0]   ref_cnt,
   output logic [TEST_W-1:0]  test_sel,
   output logic               div_load,
   output logic               ref_load
);
   generate
      if (DEF_MAIN >= (1 << MAIN_W) || DEF_SWAL >= (1 << SWAL_W) ||
          DEF_REF >= (1 << REF_W) || DEF_CP >= (1 << CP_W) ||
          DEF_TEST >= (1 << TEST_W)) begin : g_bad_def
         $error("synth_ctrl_port: default exceeds its field width");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic [WORD_W-1:0] shreg;
   logic              le_rise;
   div_cfg_t          div_q;
   ref_cfg_t          ref_q;

   sync_bits #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({ser_le, ser_data, ser_clk}),
      .dout (pins_s)
   );

   serial_shifter u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .s_clk  (pins_s[0]),
      .s_data (pins_s[1]),
      .s_le   (pins_s[2]),
      .shreg  (shreg),
      .le_rise(le_rise)
   );

   word_latch #(
      .DEF_MAIN(DEF_MAIN), .DEF_SWAL(DEF_SWAL), .DEF_CP(DEF_CP),
      .DEF_REF(DEF_REF), .DEF_TEST(DEF_TEST)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .le_rise (le_rise),
      .word    (shreg),
      .div_q   (div_q),
      .ref_q   (ref_q),
      .div_load(div_load),
      .ref_load(ref_load)
   );

   assign main_cnt    = div_q.main_cnt;
   assign swallow_cnt = div_q.swal_cnt;
   assign div_ratio   = {div_q.main_cnt, div_q.swal_cnt};
   assign cp_sel      = div_q.cp_sel;
   assign ref_cnt     = ref_q.ref_cnt;
   assign test_sel    = ref_q.test_sel;

   // R8
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_zero_chk: assert (main_cnt == '0 && ref_cnt == '0 &&
                                 !div_load && !ref_load);
      end
   end
endmodule

// File: tb/synth_ctrl_port_tb.sv
module synth_ctrl_port_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
   logic [12:0] main_cnt, ref_cnt;
   logic [4:0]  swallow_cnt;
   logic [17:0] div_ratio;
   logic [1:0]  cp_sel, test_sel;
   logic        div_load, ref_load;

   int checks = 0, errors = 0;
   int n_div = 0, n_ref = 0;

   always #10 clk = ~clk;

   synth_ctrl_port u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_le(ser_le), .main_cnt(main_cnt), .swallow_cnt(swallow_cnt),
      .div_ratio(div_ratio), .cp_sel(cp_sel), .ref_cnt(ref_cnt),
      .test_sel(test_sel), .div_load(div_load), .ref_load(ref_load)
   );

   always @(negedge clk) begin
      if (div_load) n_div++;
      if (ref_load) n_ref++;
   end

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // shifts w[n-1] first, then raises load-enable
   task automatic send_raw(input logic [31:0] w, input int n);
      ser_le = 1'b0;
      wait_n(3);
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = w[i];
         wait_n(2);
         ser_clk = 1'b1;
         wait_n(3);
         ser_clk = 1'b0;
         wait_n(2);
      end
      n_div = 0;
      n_ref = 0;
      ser_le = 1'b1;
      wait_n(10);
   endtask

   function automatic logic [22:0] div_word(input int m, input int s,
                                            input int cp, input int pad);
      logic [12:0] mm = 13'(m);
      logic [4:0]  ss = 5'(s);
      logic [1:0]  cc = 2'(cp);
      logic [1:0]  pp = 2'(pad);
      return {mm, ss, pp, cc[0], cc[1], 1'b1};
   endfunction

   function automatic logic [22:0] ref_word(input int r, input int t,
                                            input int pad);
      logic [12:0] rr = 13'(r);
      logic [1:0]  tt = 2'(t);
      logic [6:0]  pp = 7'(pad);
      return {pp, tt[0], tt[1], rr, 1'b0};
   endfunction

   task automatic chk_div(input string req, input int m, input int s, input int cp);
      chk(req, main_cnt, m);
      chk(req, swallow_cnt, s);
      chk(req, div_ratio, 32 * m + s);
      chk(req, cp_sel, cp);
   endtask

   task automatic chk_ref(input string req, input int r, input int t);
      chk(req, ref_cnt, r);
      chk(req, test_sel, t);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int m, s, r, t, last_m, last_s, last_cp, last_r, last_t;
      wait_n(4);
      // R8 reset state
      chk("R8", main_cnt, 0);
      chk("R8", div_ratio, 0);
      chk("R8", ref_cnt, 0);
      chk("R8", test_sel, 0);
      chk("R8", cp_sel, 0);
      chk("R8", n_div + n_ref, 0);
      rst_n = 1'b1;
      wait_n(5);
      // R9 defaults after release
      chk_div("R9", 324, 4, 2);
      chk("R9", div_ratio, 10372);
      chk_ref("R9", 1280, 1);
      chk("R9", n_div, 1);
      chk("R9", n_ref, 1);

      // R3 R5 R6 R10 sweep of the swallow count with varied main, select and padding
      last_r = 1280; last_t = 1;
      for (int k = 0; k < 32; k++) begin
         m = (32 + k * 251) % 8192;
         send_raw({9'b0, div_word(m, k, k % 4, k)}, 23);
         chk_div("R3", m, k, k % 4);
         chk("R6", n_div, 1);
         chk("R5", n_ref, 0);
         chk_ref("R5", last_r, last_t);
      end
      last_m = (32 + 31 * 251) % 8192; last_s = 31; last_cp = 3;

      // R4 R5 R10 reference sweep with varied test field and padding
      for (int k = 0; k < 20; k++) begin
         r = 2 + k * 409;
         t = k % 4;
         send_raw({9'b0, ref_word(r, t, k * 13 + 5)}, 23);
         chk_ref("R4", r, t);
         chk("R6", n_ref, 1);
         chk("R5", n_div, 0);
         chk_div("R5", last_m, last_s, last_cp);
      end
      last_r = 2 + 19 * 409; last_t = 3;

      // R1 MSB-first: extreme main and swallow values
      send_raw({9'b0, div_word(8191, 0, 0, 3)}, 23);
      chk_div("R1", 8191, 0, 0);
      send_raw({9'b0, div_word(1, 31, 1, 0)}, 23);
      chk_div("R1", 1, 31, 1);
      chk("R1", div_ratio, 63);

      // R10 padding all ones versus all zeros gives identical reference result
      send_raw({9'b0, ref_word(8191, 2, 127)}, 23);
      chk_ref("R10", 8191, 2);
      send_raw({9'b0, ref_word(8191, 2, 0)}, 23);
      chk_ref("R10", 8191, 2);

      // R7 five extra leading ones are pushed out
      send_raw({4'b0, 5'b11111, div_word(437, 16, 2, 0)}, 28);
      chk_div("R7", 437, 16, 2);
      chk("R7", div_ratio, 14000);

      // R2 shift-clock pulses while load-enable is high are ignored
      for (int i = 0; i < 6; i++) begin
         ser_data = 1'b1;
         wait_n(2);
         ser_clk = 1'b1;
         wait_n(3);
         ser_clk = 1'b0;
         wait_n(2);
      end
      chk_div("R2", 437, 16, 2);
      ser_le = 1'b0;
      wait_n(6);
      n_div = 0;
      n_ref = 0;
      ser_le = 1'b1;
      wait_n(10);
      chk_div("R2", 437, 16, 2);
      chk("R2", n_div, 1);
      chk("R2", n_ref, 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule